// File: doc/BRIEF.md
# Power Rail Enable and Thermal Protection Controller

This block decides, on every clock, which of eight power channels may be switched on. The eight channels are five linear regulators and three high-side switches. It merges four things: a control byte held by a serial-bus register elsewhere, a global enable pin, a digital temperature reading for each channel, and a battery overvoltage indication. Two regulators follow the enable pin alone. The other six follow their own bits of the control byte, but only while the enable pin is high.

Each channel has its own thermal latch with a trip level and a lower recovery level. Regulators and the two small switches share one window. The large switch has a wider window. A hot channel turns off only itself. An overvoltage turns every channel off. Current-limit indications are passed through as flags and never turn off a channel. All outputs are registered, so every output reflects the inputs sampled on the previous rising clock edge.

Top module: `pwr_enable_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, every output is 0 on the following cycle and every thermal latch is cleared.
- R2: Channel enables are packed with bit 0 = regulator A, 1 = B, 2 = C, 3 = D, 4 = E, 5 = large switch, 6 = small switch 1, 7 = small switch 2. When `ext_en` is 0, all eight enables are 0 whatever the control byte holds. When `ext_en` is 1, regulators B and C are requested on whatever the byte holds.
- R3: When `ext_en` is 1, the other channels take their request from the control byte: bit 7 regulator A, bit 4 regulator D, bit 3 regulator E, bit 2 large switch, bit 1 small switch 1, bit 0 small switch 2. Bit 6 has no effect on any output.
- R4: `rail_d_high` equals control-byte bit 5 (1 selects the higher output level of regulator D), whether or not `ext_en` is high.
- R5: For the five regulators and both small switches, the thermal latch sets when the channel temperature code is 160 or more. It clears when the code is 130 or less. Between those values it holds its state. Codes are unsigned degrees C, 8 bits per channel, channel i at bits [8i+7:8i] of `temp_code`.
- R6: For the large switch, the latch sets at 170 or more, clears at 120 or less, and holds between those values.
- R7: A channel whose latch is set has its enable at 0. Its `therm_flag` bit is 1, and this does not change any other channel's enable. A requested channel turns back on once its latch clears.
- R8: While `ovp` is high, all enables are 0 and `ov_flag` is 1. When `ovp` falls, the enables resume from the current requests and latches.
- R9: `ilim` has no effect on any enable or thermal flag. `ilim_flag` repeats `ilim` one cycle later.
- R10: Every output changes exactly one clock after the inputs that cause the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_byte | input | 8 | Control byte from the serial-bus register |
| ext_en | input | 1 | Global enable pin |
| temp_code | input | 64 | Per-channel temperature in degrees C, 8 bits each |
| ovp | input | 1 | Battery overvoltage indication |
| ilim | input | 8 | Per-channel current-limit indication |
| chan_en | output | 8 | Final channel enables |
| rail_d_high | output | 1 | Regulator D level select |
| therm_flag | output | 8 | Per-channel thermal shutdown state |
| ilim_flag | output | 8 | Per-channel current-limit flag |
| ov_flag | output | 1 | Overvoltage flag |

## Verification
A behavioural model in the bench predicts every output and is compared on every clock. The enable-gating phase uses all-ones, all-zeros and alternating bytes, with the enable pin first low and then high. This separates the two pin-only regulators from the byte-driven channels and exposes a swapped bit position or a decoded don't-care bit. Temperature sweeps step through one below, at, between and at the boundaries of each window on a regulator and on the large switch. These sweeps tell an off-by-one compare apart from a wrong window assignment, and show whether the latch holds between the limits. A long random phase then mixes temperatures near the limits, overvoltage pulses and current-limit noise across all channels, which shows whether one channel's fault leaks into another.

// File: rtl/pwr_ctrl_pkg.sv
package pwr_ctrl_pkg;
  localparam int NCH   = 8;   // total channels
  localparam int NREG  = 5;   // regulators occupy indices 0..NREG-1
  localparam int BIGSW = NREG; // index of the large switch
  localparam int CBW   = 8;   // control byte width

  // Control byte bit that requests channel ch; -1 means the pin alone drives it.
  function automatic int ctrl_bit_of(input int ch);
    case (ch)
      0: return 7;
      3: return 4;
      4: return 3;
      5: return 2;
      6: return 1;
      7: return 0;
      default: return -1;
    endcase
  endfunction

  localparam int LVL_BIT = 5; // regulator D level select
endpackage

// File: rtl/pwr_ctrl_map.sv
module pwr_ctrl_map
  import pwr_ctrl_pkg::*;
(
  input  logic [CBW-1:0] ctrl_byte,
  input  logic           ext_en,
  output logic [NCH-1:0] request
);
  logic unused_spare;
  assign unused_spare = ctrl_byte[6];

  for (genvar ch = 0; ch < NCH; ch++) begin : g_map
    localparam int BIT = ctrl_bit_of(ch);
    if (BIT < 0) begin : g_pin
      assign request[ch] = ext_en;
    end else begin : g_byte
      assign request[ch] = ext_en & ctrl_byte[BIT];
    end
  end
endmodule

// File: rtl/pwr_therm_latch.sv
module pwr_therm_latch #(
  parameter int TW   = 8,
  parameter int TRIP = 160,
  parameter int REC  = 130
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] temp,
  output logic          hot_next,
  output logic          hot_q
);
  localparam logic [TW-1:0] TRIP_C = TW'(TRIP);
  localparam logic [TW-1:0] REC_C  = TW'(REC);

  always_comb begin
    if (temp >= TRIP_C)     hot_next = 1'b1;
    else if (temp <= REC_C) hot_next = 1'b0;
    else                    hot_next = hot_q;
  end

  always_ff @(posedge clk) begin
    if (rst) hot_q <= 1'b0;
    else     hot_q <= hot_next;
  end

  // R5 and R6 share this latch; the window comes from the parameters
  p_trip_sets_r5: assert property (@(posedge clk) disable iff (rst)
    (temp >= TRIP_C) |=> hot_q);
  p_recover_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (temp <= REC_C) |=> !hot_q);
  p_hold_window_r5: assert property (@(posedge clk) disable iff (rst)
    (temp > REC_C && temp < TRIP_C) |=> $stable(hot_q));
endmodule

// File: rtl/pwr_enable_ctrl.sv
module pwr_enable_ctrl
  import pwr_ctrl_pkg::*;
#(
  parameter int TW        = 8,
  parameter int STD_TRIP  = 160,
  parameter int STD_REC   = 130,
  parameter int BIG_TRIP  = 170,
  parameter int BIG_REC   = 120
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CBW-1:0]    ctrl_byte,
  input  logic              ext_en,
  input  logic [NCH*TW-1:0] temp_code,
  input  logic              ovp,
  input  logic [NCH-1:0]    ilim,
  output logic [NCH-1:0]    chan_en,
  output logic              rail_d_high,
  output logic [NCH-1:0]    therm_flag,
  output logic [NCH-1:0]    ilim_flag,
  output logic              ov_flag
);
  logic [NCH-1:0] request;
  logic [NCH-1:0] hot_next;

  pwr_ctrl_map u_map (
    .ctrl_byte (ctrl_byte),
    .ext_en    (ext_en),
    .request   (request)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_therm
    localparam int TRIP = (ch == BIGSW) ? BIG_TRIP : STD_TRIP;
    localparam int REC  = (ch == BIGSW) ? BIG_REC  : STD_REC;
    pwr_therm_latch #(.TW(TW), .TRIP(TRIP), .REC(REC)) u_latch (
      .clk      (clk),
      .rst      (rst),
      .temp     (temp_code[ch*TW +: TW]),
      .hot_next (hot_next[ch]),
      .hot_q    (therm_flag[ch])
    );
  end

  // current limiting is reported only; it never gates an enable
  always_ff @(posedge clk) begin
    if (rst) begin
      chan_en     <= '0;
      rail_d_high <= 1'b0;
      ilim_flag   <= '0;
      ov_flag     <= 1'b0;
    end else begin
      chan_en     <= ovp ? '0 : (request & ~hot_next);
      rail_d_high <= ctrl_byte[LVL_BIT];
      ilim_flag   <= ilim;
      ov_flag     <= ovp;
    end
  end

  p_ov_off_r8: assert property (@(posedge clk) disable iff (rst)
    ovp |=> (chan_en == '0 && ov_flag));
  p_pin_gate_r2: assert property (@(posedge clk) disable iff (rst)
    !ext_en |=> (chan_en == '0));
  p_hot_off_r7: assert property (@(posedge clk) disable iff (rst)
    (chan_en & therm_flag) == '0);
  p_level_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (rail_d_high == $past(ctrl_byte[LVL_BIT])));
endmodule

// File: tb/pwr_enable_ctrl_test.sv
module pwr_enable_ctrl_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  ctrl_byte;
  logic        ext_en;
  logic [63:0] temp_code;
  logic        ovp;
  logic [7:0]  ilim;
  logic [7:0]  chan_en, therm_flag, ilim_flag;
  logic        rail_d_high, ov_flag;

  int checks = 0;
  int errors = 0;
  string req = "R1";

  always #10 clk = ~clk;

  pwr_enable_ctrl uut (
    .clk(clk), .rst(rst), .ctrl_byte(ctrl_byte), .ext_en(ext_en),
    .temp_code(temp_code), .ovp(ovp), .ilim(ilim), .chan_en(chan_en),
    .rail_d_high(rail_d_high), .therm_flag(therm_flag),
    .ilim_flag(ilim_flag), .ov_flag(ov_flag)
  );

  // behavioural reference
  logic [7:0] m_en, m_th, m_il;
  logic       m_lvl, m_ov;

  function automatic int byte_pos(input int ch);
    case (ch)
      0: return 7;
      3: return 4;
      4: return 3;
      5: return 2;
      6: return 1;
      7: return 0;
      default: return -1;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_th = 0; m_il = 0; m_lvl = 0; m_ov = 0;
    end else begin
      for (int i = 0; i < 8; i++) begin
        int t, hi, lo;
        bit want;
        t  = int'(temp_code[i*8 +: 8]);
        hi = (i == 5) ? 170 : 160;
        lo = (i == 5) ? 120 : 130;
        if (t >= hi) m_th[i] = 1'b1;
        else if (t <= lo) m_th[i] = 1'b0;
        if (byte_pos(i) < 0) want = ext_en;
        else want = ext_en && ctrl_byte[byte_pos(i)];
        m_en[i] = want && !m_th[i] && !ovp;
      end
      m_il = ilim; m_lvl = ctrl_byte[5]; m_ov = ovp;
    end
  end

  task automatic cmp8(input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cmp8("chan_en", chan_en, m_en);
    cmp8("therm_flag", therm_flag, m_th);
    cmp8("ilim_flag", ilim_flag, m_il);
    cmp8("rail_d_high", {7'd0, rail_d_high}, {7'd0, m_lvl});
    cmp8("ov_flag", {7'd0, ov_flag}, {7'd0, m_ov});
  endtask

  task automatic set_temp(input int ch, input int val);
    temp_code[ch*8 +: 8] = 8'(val);
  endtask

  task automatic all_temp(input int val);
    for (int i = 0; i < 8; i++) set_temp(i, val);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst = 1; ctrl_byte = 8'hFF; ext_en = 1; ovp = 0; ilim = 8'hFF;
    all_temp(200);
    // R1: reset holds all outputs low despite active inputs
    req = "R1 reset";
    repeat (3) step();
    rst = 0; all_temp(25); ilim = 0;
    @(negedge clk);

    // R2 pin gating, R3 byte mapping, R4 level select, R10 latency
    req = "R2 pin low gates all";
    ext_en = 0;
    foreach (ctrl_byte[i]) ;
    ctrl_byte = 8'hFF; step(); step();
    ctrl_byte = 8'hA5; step();
    req = "R2 pin high, R3 byte map";
    ext_en = 1;
    ctrl_byte = 8'h00; step();
    ctrl_byte = 8'hFF; step();
    ctrl_byte = 8'hA5; step();
    ctrl_byte = 8'h5A; step();
    req = "R3 spare bit6 ignored";
    ctrl_byte = 8'h40; step();
    ctrl_byte = 8'hBF; step();
    req = "R4 level select with pin low";
    ext_en = 0; ctrl_byte = 8'h20; step();
    ctrl_byte = 8'h00; step();
    req = "R10 byte kept across pin";
    ctrl_byte = 8'h9E; step(); ext_en = 1; step();

    // R5 standard window on regulator D (index 3), R7 isolation
    req = "R5 standard window";
    ctrl_byte = 8'hFF;
    foreach (ctrl_byte[i]) ;
    set_temp(3, 159); step();
    set_temp(3, 160); step();
    req = "R7 hot channel isolated";
    set_temp(3, 145); step();
    set_temp(3, 131); step();
    req = "R5 recover at limit";
    set_temp(3, 130); step();
    set_temp(3, 150); step();
    // R6 wide window on the large switch (index 5)
    req = "R6 large switch window";
    set_temp(5, 160); step();
    set_temp(5, 169); step();
    set_temp(5, 170); step();
    set_temp(5, 125); step();
    set_temp(5, 121); step();
    set_temp(5, 120); step();
    req = "R5 small switch window";
    set_temp(7, 160); step(); set_temp(7, 131); step(); set_temp(7, 130); step();

    // R8 overvoltage
    req = "R8 overvoltage";
    ovp = 1; step(); step();
    ovp = 0; step();
    // R9 current limit ignored
    req = "R9 current limit ignored";
    ilim = 8'hFF; step();
    ilim = 8'h5A; step();
    ilim = 8'h00; step();

    // random mix
    req = "R2 R3 R5 R6 R7 R8 R9 random mix";
    for (int n = 0; n < 3000; n++) begin
      ctrl_byte = 8'($urandom);
      ext_en = ($urandom_range(0, 9) != 0);
      ovp = ($urandom_range(0, 19) == 0);
      ilim = 8'($urandom);
      for (int i = 0; i < 8; i++) set_temp(i, $urandom_range(110, 180));
      step();
    end

    req = "R1 reset again";
    rst = 1; step(); step();
    finish_run();
  end
endmodule